// File: doc/BRIEF.md
# ADC Autoscan Sequencer

This block walks a set of up to eight analog input channels through an external conversion engine, one channel at a time. Software picks the participating channels with a bit-per-channel mask, chooses a divider setting for the spacing between conversions, and starts a scan. A scan starts either from a control register write or from a rising edge on an external trigger pin. For every enabled channel the sequencer raises a conversion request with the channel number and holds it until the engine returns a one-cycle done pulse with a 10-bit result. The result is then stored in that channel's own result register.

A scan either makes a single pass over the enabled channels or repeats until software withdraws the repeat bit. A single interrupt flag is raised at the end of every complete pass, not after each conversion. The flag is sticky until software acknowledges it. Registers sit on a simple write-strobe / combinational-read bus. Address 0 is control, address 1 is the channel mask, and addresses 8 to 15 hold the results of channels 0 to 7.

Top module: `adc_scan_seq`

## Requirements
- R1: Each channel i has its own result register, read at address 8+i in bits [9:0] with bits above 9 reading zero. It is written only when the engine signals done for channel i.
- R2: Mask bit i (address 1) enables channel i. The mask is captured at the start of each pass. Only captured channels are requested, in ascending index order, starting with the lowest set bit.
- R3: With the repeat bit (control bit 1) clear, a started scan makes exactly one pass and then goes idle. The busy bit (control bit 0 on read) then reads 0.
- R4: With the repeat bit set, passes follow one another without limit. Clearing the bit lets the pass in progress finish, after which the block goes idle.
- R5: Writing 1 to control bit 0 starts a scan. A rising edge on ext_start also starts one, but only while control bit 2 is set; otherwise the pin has no effect.
- R6: The interrupt flag (irq, readable at control bit 3) is set in the cycle after the done pulse that ends a pass. It stays set until a control write with bit 3 = 1. If a pass ends in the same cycle as such a write, the flag is set.
- R7: The divider field (control bits 5:4, value p) gives m = 2*(p+1). After a start, cnv_req rises m cycles later. After each done pulse, cnv_req stays low for exactly m cycles before the next request.
- R8: Starting a scan with an all-zero mask performs no conversion and leaves the interrupt flag clear.
- R9: A start of either kind that arrives while a scan is running is ignored: the running pass is neither restarted nor lengthened.
- R10: cnv_req stays high with a stable cnv_chan until cnv_done. A cnv_done pulse while no request is pending changes no result register.
- R11: After reset, cnv_req and irq are low, and the control, mask and result registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0 control, 1 mask, 8+i result i) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| ext_start | input | 1 | External scan trigger, rising-edge sensitive |
| cnv_req | output | 1 | Conversion request to the engine |
| cnv_chan | output | 3 | Channel to convert |
| cnv_done | input | 1 | One-cycle pulse: conversion finished |
| cnv_result | input | 10 | Result accompanying cnv_done |
| irq | output | 1 | Sticky end-of-pass interrupt flag |

## Verification
Two functions can fall in the same cycle: the end-of-pass flag set and a software acknowledge write. The engine model in the bench provokes this by driving the acknowledge write on the same falling edge on which it raises the done pulse for the last enabled channel, so both reach the same rising clock edge. The test passes only if the flag reads 1 afterwards. A start write and an external trigger are also fired into the middle of a running pass. The bench then checks that the logged channel sequence holds exactly one pass.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_CONV = 2'd2
  } scan_st_e;

  // control register bit positions
  localparam int CTL_GO   = 0;
  localparam int CTL_LOOP = 1;
  localparam int CTL_EXT  = 2;
  localparam int CTL_ACK  = 3;
  localparam int CTL_DIV  = 4;
  localparam int DIV_W    = 2;
endpackage

// File: rtl/adc_scan_ctl.sv
module adc_scan_ctl
  import adc_scan_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              ext_start,
  input  logic              loop_done,
  output logic              loop_en,
  output logic              ext_en,
  output logic [DIV_W-1:0]  div_sel,
  output logic [NCH-1:0]    sel_mask,
  output logic              go,
  output logic              irq
);
  logic ctl_wr, mask_wr, ack, ext_q, irq_d;
  logic unused_wd;

  assign unused_wd = ^reg_wdata[DATA_W-1:NCH];
  assign ctl_wr  = reg_we && (reg_addr == ADDR_W'(0));
  assign mask_wr = reg_we && (reg_addr == ADDR_W'(1));
  assign ack     = ctl_wr && reg_wdata[CTL_ACK];
  assign go      = (ctl_wr && reg_wdata[CTL_GO]) || (ext_en && ext_start && !ext_q);

  always_comb begin
    irq_d = irq;
    if (ack)       irq_d = 1'b0;
    if (loop_done) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_en  <= 1'b0;
      ext_en   <= 1'b0;
      div_sel  <= '0;
      sel_mask <= '0;
      ext_q    <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ext_q <= ext_start;
      irq   <= irq_d;
      if (ctl_wr) begin
        loop_en <= reg_wdata[CTL_LOOP];
        ext_en  <= reg_wdata[CTL_EXT];
        div_sel <= reg_wdata[CTL_DIV +: DIV_W];
      end
      if (mask_wr) sel_mask <= reg_wdata[NCH-1:0];
    end
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |=> irq); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack |=> irq); // R6
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !loop_done |=> !irq); // R6
endmodule

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic [NCH-1:0] cand,
  input  logic [CW-1:0]  after,
  input  logic           from_base,
  output logic           hit,
  output logic [CW-1:0]  idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i] && (from_base || (i > int'(after)))) begin
        hit = 1'b1;
        idx = CW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             loop_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [NCH-1:0]   sel_mask,
  input  logic             cnv_done,
  output logic             cnv_req,
  output logic [CW-1:0]    cnv_chan,
  output logic             busy,
  output logic             loop_done,
  output logic             wr_en
);
  localparam int GW = DIV_W + 1;

  scan_st_e       st, st_d;
  logic [CW-1:0]  chan, chan_d;
  logic [NCH-1:0] scan_mask, scan_d;
  logic [GW-1:0]  gap, gap_d, gap_load;
  logic           first_hit, next_hit;
  logic [CW-1:0]  first_idx, next_idx;

  adc_scan_pick #(.NCH(NCH), .CW(CW)) i_first (
    .cand(sel_mask), .after('0), .from_base(1'b1), .hit(first_hit), .idx(first_idx));
  adc_scan_pick #(.NCH(NCH), .CW(CW)) i_next (
    .cand(scan_mask), .after(chan), .from_base(1'b0), .hit(next_hit), .idx(next_idx));

  assign gap_load = {div_sel, 1'b1};
  assign cnv_req  = (st == ST_CONV);
  assign cnv_chan = chan;
  assign busy     = (st != ST_IDLE);
  assign wr_en    = cnv_req && cnv_done;

  always_comb begin
    st_d      = st;
    chan_d    = chan;
    scan_d    = scan_mask;
    gap_d     = gap;
    loop_done = 1'b0;
    case (st)
      ST_IDLE: if (go && first_hit) begin
        st_d   = ST_GAP;
        chan_d = first_idx;
        scan_d = sel_mask;
        gap_d  = gap_load;
      end
      ST_GAP: begin
        if (gap == '0) st_d = ST_CONV;
        else           gap_d = GW'(gap - 1'b1);
      end
      ST_CONV: if (cnv_done) begin
        if (next_hit) begin
          st_d   = ST_GAP;
          chan_d = next_idx;
          gap_d  = gap_load;
        end else begin
          loop_done = 1'b1;
          if (loop_en && first_hit) begin
            st_d   = ST_GAP;
            chan_d = first_idx;
            scan_d = sel_mask;
            gap_d  = gap_load;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      chan      <= '0;
      scan_mask <= '0;
      gap       <= '0;
    end else begin
      st        <= st_d;
      chan      <= chan_d;
      scan_mask <= scan_d;
      gap       <= gap_d;
    end
  end

  AST_REQ_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_req |-> scan_mask[chan]); // R2
  AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_req && cnv_done && !loop_done |=> chan > $past(chan)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_req && !cnv_done |=> cnv_req && $stable(chan)); // R10
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_req && cnv_done |=> !cnv_req); // R7
  AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && go && (sel_mask == '0) |=> !busy); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && go && !cnv_done |=> $stable(chan) && $stable(scan_mask)); // R9
endmodule

// File: rtl/adc_scan_bank.sv
module adc_scan_bank #(
  parameter int NCH   = 8,
  parameter int CW    = 3,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CW-1:0]    wr_ch,
  input  logic [RES_W-1:0] wr_val,
  output logic [RES_W-1:0] res_q [NCH]
);
  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_ch == CW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   res_q[g] <= '0;
      else if (hit) res_q[g] <= wr_val;
    end

    AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_ch == CW'(g))) |=> $stable(res_q[g])); // R1
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter  int NCH    = 8,
  parameter  int RES_W  = 10,
  parameter  int DATA_W = 16,
  localparam int CW     = $clog2(NCH),
  localparam int ADDR_W = CW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_start,
  output logic              cnv_req,
  output logic [CW-1:0]     cnv_chan,
  input  logic              cnv_done,
  input  logic [RES_W-1:0]  cnv_result,
  output logic              irq
);
  logic             loop_en, ext_en, go, busy, loop_done, wr_en;
  logic [DIV_W-1:0] div_sel;
  logic [NCH-1:0]   sel_mask;
  logic [RES_W-1:0] res_q [NCH];

  adc_scan_ctl #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ext_start(ext_start), .loop_done(loop_done),
    .loop_en(loop_en), .ext_en(ext_en), .div_sel(div_sel),
    .sel_mask(sel_mask), .go(go), .irq(irq));

  adc_scan_fsm #(.NCH(NCH), .CW(CW)) i_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .loop_en(loop_en), .div_sel(div_sel),
    .sel_mask(sel_mask), .cnv_done(cnv_done), .cnv_req(cnv_req),
    .cnv_chan(cnv_chan), .busy(busy), .loop_done(loop_done), .wr_en(wr_en));

  adc_scan_bank #(.NCH(NCH), .CW(CW), .RES_W(RES_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(cnv_chan),
    .wr_val(cnv_result), .res_q(res_q));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[ADDR_W-1])
      reg_rdata = DATA_W'(res_q[reg_addr[CW-1:0]]);
    else if (reg_addr == ADDR_W'(0))
      reg_rdata = DATA_W'({div_sel, irq, ext_en, loop_en, busy});
    else if (reg_addr == ADDR_W'(1))
      reg_rdata = DATA_W'(sel_mask);
  end

  AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnv_done)); // R6
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_start = 1'b0;
  logic        cnv_req;
  logic [2:0]  cnv_chan;
  logic        cnv_done = 1'b0;
  logic [9:0]  cnv_result = '0;
  logic        irq;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_start(ext_start),
    .cnv_req(cnv_req), .cnv_chan(cnv_chan), .cnv_done(cnv_done),
    .cnv_result(cnv_result), .irq(irq));

  always #(CLK_PER/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, nlog = 0, seq = 0;
  int cur_m = 2, ref_cyc = 0, exp_dly = 0, eng_cnt = 0, clr_at = -1;
  bit ref_valid = 0, prev_req = 0, manual = 0, clr_pend = 0, finished = 0;
  logic [2:0]  log_ch [0:1023];
  logic [9:0]  exp_res [8];
  logic [15:0] ctl_sh = '0;

  always @(posedge clk) cyc++;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] res_of(int ch, int s);
    return 10'((ch * 137 + s * 29 + 5) & 1023);
  endfunction

  // conversion engine model
  always @(negedge clk) begin
    if (rst_n && !manual) begin
      if (cnv_done) begin
        cnv_done = 1'b0;
        if (clr_pend) begin reg_we = 1'b0; clr_pend = 0; end
      end else if (cnv_req) begin
        if (!prev_req && ref_valid) begin
          chk("R7 request spacing", cyc - ref_cyc, exp_dly);
          ref_valid = 0;
        end
        if (eng_cnt == 0) eng_cnt = 1 + int'($urandom % 5);
        else begin
          eng_cnt--;
          if (eng_cnt == 0) begin
            cnv_result = res_of(int'(cnv_chan), seq);
            exp_res[cnv_chan] = cnv_result;
            seq++;
            cnv_done = 1'b1;
            log_ch[nlog] = cnv_chan;
            nlog++;
            ref_cyc = cyc; exp_dly = cur_m + 1; ref_valid = 1;
            if (clr_at == nlog) begin
              reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = ctl_sh | 16'h8;
              clr_pend = 1;
            end
          end
        end
      end
      prev_req = cnv_req;
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic set_ctl(int pre, bit loop, bit ext);
    ctl_sh = 16'((pre << 4) | (int'(ext) << 2) | (int'(loop) << 1));
    cur_m = 2 * (pre + 1);
    wr(4'd0, ctl_sh);
  endtask

  task automatic start_sw();
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = ctl_sh | 16'h1;
    @(negedge clk); reg_we = 1'b0;
    ref_cyc = cyc; exp_dly = cur_m; ref_valid = 1;
  endtask

  task automatic start_ext();
    @(negedge clk); ext_start = 1'b1;
    @(negedge clk); ext_start = 1'b0;
    ref_cyc = cyc; exp_dly = cur_m; ref_valid = 1;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int k = 0; k < 5000; k++) begin
      rd(4'd0, v);
      if (!v[0]) return;
    end
    chk("R3 idle timeout", 1, 0);
  endtask

  task automatic chk_order(logic [7:0] m, int base, int loops);
    int pop = 0;
    int lst [8];
    for (int i = 0; i < 8; i++) if (m[i]) begin lst[pop] = i; pop++; end
    chk("R3 conversion count", nlog - base, pop * loops);
    if (pop > 0)
      for (int k = 0; k < nlog - base && k < pop * loops; k++)
        chk("R2 channel order", int'(log_ch[base + k]), lst[k % pop]);
  endtask

  task automatic chk_results();
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(4'(8 + i), v);
      chk("R1 result register", int'(v), int'(exp_res[i]));
    end
  endtask

  task automatic one_pass(logic [7:0] m, int pre, bit use_ext);
    logic [15:0] v;
    int base;
    set_ctl(pre, 1'b0, use_ext);
    wr(4'd1, 16'(m));
    base = nlog;
    if (use_ext) start_ext(); else start_sw();
    wait_idle();
    chk_order(m, base, 1);
    chk_results();
    rd(4'd0, v);
    if (m != 0) chk("R6 irq after pass", int'(v[3]), 1);
    else        chk("R8 empty mask no irq", int'(v[3]), 0);
    wr(4'd0, ctl_sh | 16'h8);
    rd(4'd0, v);
    chk("R6 irq acknowledged", int'(v[3]), 0);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic [15:0] v;
    int base, dummy;
    dummy = int'($urandom(32'h1357));
    for (int i = 0; i < 8; i++) exp_res[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk("R11 cnv_req after reset", int'(cnv_req), 0);
    chk("R11 irq after reset", int'(irq), 0);
    rd(4'd0, v); chk("R11 control reset", int'(v), 0);
    rd(4'd1, v); chk("R11 mask reset", int'(v), 0);
    chk_results();

    // directed corners
    one_pass(8'h01, 0, 1'b0);
    one_pass(8'h80, 3, 1'b1);
    one_pass(8'hFF, 1, 1'b0);
    one_pass(8'h00, 2, 1'b0);   // R8
    one_pass(8'h00, 0, 1'b1);   // R8 via trigger pin

    // constrained random passes
    for (int t = 0; t < 14; t++)
      one_pass(8'($urandom), int'($urandom % 4), 1'($urandom));

    // R4 repeat mode, stopped during the third pass
    set_ctl(0, 1'b1, 1'b0);
    wr(4'd1, 16'h5A);
    base = nlog;
    start_sw();
    wait (nlog >= base + 9);
    ctl_sh = ctl_sh & ~16'h2;
    wr(4'd0, ctl_sh);
    wait_idle();
    chk("R4 three passes then idle", nlog - base, 12);
    chk_order(8'h5A, base, 3);
    wr(4'd0, ctl_sh | 16'h8);

    // R9 starts during a running pass are ignored
    set_ctl(1, 1'b0, 1'b1);
    wr(4'd1, 16'h0F);
    base = nlog;
    start_sw();
    wait (nlog >= base + 1);
    wr(4'd0, ctl_sh | 16'h1);
    @(negedge clk); ext_start = 1'b1;
    @(negedge clk); ext_start = 1'b0;
    wait_idle();
    chk("R9 busy start ignored", nlog - base, 4);
    chk_order(8'h0F, base, 1);
    wr(4'd0, ctl_sh | 16'h8);

    // R5 trigger pin ignored while disabled
    set_ctl(0, 1'b0, 1'b0);
    wr(4'd1, 16'hFF);
    base = nlog;
    @(negedge clk); ext_start = 1'b1;
    @(negedge clk); ext_start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R5 disabled trigger no request", nlog - base, 0);
    rd(4'd0, v); chk("R5 disabled trigger not busy", int'(v[0]), 0);

    // R10 stray done pulse while idle
    manual = 1;
    @(negedge clk); cnv_result = ~exp_res[3]; cnv_done = 1'b1;
    @(negedge clk); cnv_done = 1'b0;
    manual = 0;
    rd(4'd11, v); chk("R10 stray done ignored", int'(v), int'(exp_res[3]));

    // R6 pass end and acknowledge in the same cycle
    set_ctl(0, 1'b0, 1'b0);
    wr(4'd1, 16'h06);
    base = nlog;
    clr_at = base + 2;
    start_sw();
    wait (nlog == base + 2);
    repeat (4) @(negedge clk);
    clr_at = -1;
    wait_idle();
    rd(4'd0, v); chk("R6 set wins over acknowledge", int'(v[3]), 1);
    wr(4'd0, ctl_sh | 16'h8);
    rd(4'd0, v); chk("R6 later acknowledge clears", int'(v[3]), 0);
    chk_results();

    finished = 1;
    report();
  end
endmodule